// File: doc/BRIEF.md
# Four-Phase Machine-Cycle Sequencer with Shared Resync Hold

The sequencer divides a machine cycle into four phases, Q1 to Q4, and moves through them in that order, one phase per rising edge of the oscillator clock. Several sequencers can run from one oscillator and be brought into phase lock through a single shared, active-low hold line. Any sequencer may pull that line low, and the line reads low while any of them pulls it. While the line is low, each sequencer keeps advancing through Q1 to Q3 and then waits in Q4. On the first edge at which the line reads high again, every waiting sequencer enters Q1, so all copies start the next machine cycle on the same clock.

Each copy has its own resync scheduler. After reset the scheduler pulls the line low for a start-up window, which covers copies that leave reset at different times. When periodic resync is enabled, the scheduler counts clocks from the edge at which the line is released. After a programmable number of edges it pulls the line low again for a four-edge window. All copies count from the same release edge, so copies with the same interval also start their windows together.

The outputs are the phase as a one-hot vector, a strobe on each wrap into Q1, and a strobe that marks a completed resync. The block has no data path, so it has no valid/ready interface. All of its pins are plain control and status levels.

Top module: `quad_phase_seq`

## Requirements
- R1: During reset and at the first clock after it, `phase` is 4'b0001 (Q1), `cycle_start` and `sync_done` are 0, and `hold_drive` is 1.
- R2: `phase` is always one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. While `hold_n_in` reads high, the phase advances Q1→Q2→Q3→Q4→Q1, one step per clock edge.
- R3: At an edge where the phase is Q4 and `hold_n_in` reads low, the phase stays Q4.
- R4: The level of `hold_n_in` has no effect on the Q1→Q2, Q2→Q3 and Q3→Q4 steps.
- R5: At an edge where the phase is Q4 and `hold_n_in` reads high, the phase becomes Q1.
- R6: `cycle_start` is 1 for exactly the cycles in which the phase is Q1 having been Q4 one cycle earlier. It is 0 in the Q1 cycles that follow reset.
- R7: `sync_done` is 1 for one cycle, in the Q1 cycle entered from Q4 at an edge where `hold_n_in` reads high and had read low at the previous edge. A release seen in any other phase gives no pulse.
- R8: After reset is released, `hold_drive` stays 1 for `STARTUP_LEN` clock edges (default 4), then drops to 0.
- R9: With `resync_en` = 1 and `resync_interval` = N ≥ 1, `hold_drive` rises at the Nth clock edge after the edge at which `hold_n_in` is first read high following a low. It then stays 1 for `SYNC_LEN` edges (4). The count pauses while the line is low.
- R10: With `resync_en` = 0 or `resync_interval` = 0, `hold_drive` stays 0 once the start-up window is over.
- R11: When copies share the line (the line is the AND of every copy's `!hold_drive`), they are all in the same phase after each release, and their schedulers raise `hold_drive` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one phase per rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hold_n_in | input | 1 | Level sensed on the shared hold line (0 = held) |
| hold_drive | output | 1 | 1 = this copy pulls the shared line low |
| resync_en | input | 1 | Enables periodic resync windows |
| resync_interval | input | CNT_W (32) | Edges from a release to the next window; 0 disables |
| phase | output | 4 | One-hot phase, bit 0 = Q1 … bit 3 = Q4 |
| cycle_start | output | 1 | One-cycle strobe on each entry into Q1 from Q4 |
| sync_done | output | 1 | One-cycle strobe when a held Q4 is released into Q1 |

## Verification
The bound checker checks the following on every cycle: the one-hot phase, the fixed steps from Q1 to Q4, waiting in Q4 and release from it, that each strobe is tied to a wrap from Q4, that a drive window never runs longer than its limit, and that the drive stays low while periodic resync is disabled. Other behaviours can only be shown by bench scenarios. These are the exact start-up and periodic window lengths, the count of N edges measured from the shared release, and that no window follows when the interval is zero. They also include phase alignment across three copies that leave reset at different times, or that one bench-forced stall has put out of step before a scheduled window brings them back.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_W       = $clog2(NUM_PHASES);

  typedef enum logic [PH_W-1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic {
    SCH_IDLE  = 1'b0,
    SCH_DRIVE = 1'b1
  } sched_e;
endpackage

// File: rtl/qps_phase_ctr.sv
module qps_phase_ctr
  import qps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_n_in,
  output phase_e phase_q,
  output logic   cycle_start,
  output logic   sync_done,
  output logic   release_seen
);
  logic            hold_q;
  logic [PH_W-1:0] step_val;
  logic            at_last;

  assign at_last      = (phase_q == PH_Q4);
  assign step_val     = phase_q + PH_W'(1);
  // line reads high now after reading low at the previous edge
  assign release_seen = hold_n_in && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_Q1;
      hold_q      <= 1'b1;
      cycle_start <= 1'b0;
      sync_done   <= 1'b0;
    end else begin
      hold_q      <= hold_n_in;
      cycle_start <= at_last && hold_n_in;
      sync_done   <= at_last && release_seen;
      if (at_last) begin
        if (hold_n_in) phase_q <= PH_Q1;
      end else begin
        phase_q <= phase_e'(step_val);
      end
    end
  end
endmodule

// File: rtl/qps_sched.sv
module qps_sched
  import qps_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int STARTUP_LEN = 4,
  parameter int SYNC_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n_in,
  input  logic             release_seen,
  input  logic             resync_en,
  input  logic [CNT_W-1:0] interval,
  output logic             hold_drive
);
  localparam int LEFT_MAX = (STARTUP_LEN > SYNC_LEN) ? STARTUP_LEN : SYNC_LEN;
  localparam int LEFT_W   = $clog2(LEFT_MAX + 1);

  sched_e            state_q;
  logic [LEFT_W-1:0] left_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              due;

  assign due = resync_en && (interval != '0) && !release_seen &&
               hold_n_in && (cnt_q >= interval - CNT_W'(1));
  assign hold_drive = (state_q == SCH_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (release_seen) begin
      cnt_q <= '0;
    end else if (state_q == SCH_IDLE && hold_n_in && cnt_q != '1) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_DRIVE;
      left_q  <= LEFT_W'(STARTUP_LEN - 1);
    end else begin
      case (state_q)
        SCH_DRIVE: begin
          if (left_q == '0) state_q <= SCH_IDLE;
          else              left_q  <= left_q - LEFT_W'(1);
        end
        default: begin
          if (due) begin
            state_q <= SCH_DRIVE;
            left_q  <= LEFT_W'(SYNC_LEN - 1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import qps_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int STARTUP_LEN = 4,
  parameter int SYNC_LEN    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_n_in,
  output logic                  hold_drive,
  input  logic                  resync_en,
  input  logic [CNT_W-1:0]      resync_interval,
  output logic [NUM_PHASES-1:0] phase,
  output logic                  cycle_start,
  output logic                  sync_done
);
  phase_e ph_q;
  logic   release_seen;

  qps_phase_ctr u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_n_in    (hold_n_in),
    .phase_q      (ph_q),
    .cycle_start  (cycle_start),
    .sync_done    (sync_done),
    .release_seen (release_seen)
  );

  qps_sched #(
    .CNT_W       (CNT_W),
    .STARTUP_LEN (STARTUP_LEN),
    .SYNC_LEN    (SYNC_LEN)
  ) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_n_in    (hold_n_in),
    .release_seen (release_seen),
    .resync_en    (resync_en),
    .interval     (resync_interval),
    .hold_drive   (hold_drive)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_onehot
    assign phase[g] = (ph_q == PH_W'(g));
  end
endmodule

// File: rtl/qps_checker.sv
module qps_checker #(
  parameter int STARTUP_LEN = 4,
  parameter int SYNC_LEN    = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_n_in,
  input logic       hold_drive,
  input logic       resync_en,
  input logic [3:0] phase,
  input logic       cycle_start,
  input logic       sync_done
);
  localparam int MAXW  = (STARTUP_LEN > SYNC_LEN) ? STARTUP_LEN : SYNC_LEN;
  localparam int RUN_W = $clog2(MAXW + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= '0;
    else if (!hold_drive)              run_q <= '0;
    else if (run_q != '1)              run_q <= run_q + RUN_W'(1);
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  a_r4_q1_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]);
  a_r4_q2_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase[1] |=> phase[2]);
  a_r4_q3_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase[2] |=> phase[3]);
  a_r3_park: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !hold_n_in) |=> phase[3]);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && hold_n_in) |=> phase[0]);
  a_r6_strobe_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (phase[0] && $past(phase[3])));
  a_r7_done_in_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> cycle_start);
  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_drive && run_q >= RUN_W'(MAXW - 1)) |=> !hold_drive);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync_en && !hold_drive) |=> !hold_drive);
endmodule

bind quad_phase_seq qps_checker #(
  .STARTUP_LEN (STARTUP_LEN),
  .SYNC_LEN    (SYNC_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_n_in   (hold_n_in),
  .hold_drive  (hold_drive),
  .resync_en   (resync_en),
  .phase       (phase),
  .cycle_start (cycle_start),
  .sync_done   (sync_done)
);

// File: tb/quad_phase_seq_test.sv
module quad_phase_seq_test;
  localparam int CW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_a, rst_b, rst_c, iso_c, pull, pull_c, en;
  logic [CW-1:0] ival;
  logic drv_a, drv_b, drv_c, cs_a, cs_b, cs_c, dn_a, dn_b, dn_c;
  logic [3:0] ph_a, ph_b, ph_c;
  logic line, line_c;

  assign line   = !pull && !drv_a && !drv_b && !(drv_c && !iso_c);
  assign line_c = iso_c ? (!drv_c && !pull_c) : line;

  quad_phase_seq uut (.clk(clk), .rst_n(rst_a), .hold_n_in(line), .hold_drive(drv_a),
    .resync_en(en), .resync_interval(ival), .phase(ph_a), .cycle_start(cs_a), .sync_done(dn_a));
  quad_phase_seq uut_b (.clk(clk), .rst_n(rst_b), .hold_n_in(line), .hold_drive(drv_b),
    .resync_en(en), .resync_interval(ival), .phase(ph_b), .cycle_start(cs_b), .sync_done(dn_b));
  quad_phase_seq uut_c (.clk(clk), .rst_n(rst_c), .hold_n_in(line_c), .hold_drive(drv_c),
    .resync_en(en), .resync_interval(ival), .phase(ph_c), .cycle_start(cs_c), .sync_done(dn_c));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {pull, expected phase, cycle_start, sync_done}; starts from Q1
  localparam logic [6:0] VEC [17] = '{
    7'b0_0010_0_0, 7'b0_0100_0_0, 7'b0_1000_0_0, 7'b0_0001_1_0,
    7'b1_0010_0_0, 7'b1_0100_0_0, 7'b1_1000_0_0, 7'b1_1000_0_0,
    7'b1_1000_0_0, 7'b0_0001_1_1, 7'b0_0010_0_0, 7'b1_0100_0_0,
    7'b0_1000_0_0, 7'b1_1000_0_0, 7'b0_0001_1_1, 7'b1_0010_0_0,
    7'b0_0100_0_0
  };

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int na, m, w, quiet, wait_n;
    rst_a = 0; rst_b = 0; rst_c = 0; iso_c = 0; pull = 0; pull_c = 0;
    en = 0; ival = 40;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", ph_a, 4'b0001);
    chk("R1 cycle_start", cs_a, 0);
    chk("R1 sync_done", dn_a, 0);
    chk("R1 hold_drive", drv_a, 1);

    // staggered reset release; startup windows overlap
    na = 0;
    for (int k = 0; k < 12; k++) begin
      if (k == 0) rst_a = 1;
      if (k == 1) rst_b = 1;
      if (k == 3) rst_c = 1;
      if (drv_a) na++;
      if (k == 1) chk("R1 no strobe after reset", cs_a, 0);
      if (k == 7) chk("R3 parked in Q4", ph_a, 4'b1000);
      if (k == 8) begin
        chk("R5 release to Q1", ph_a, 4'b0001);
        chk("R6 strobe on wrap", cs_a, 1);
        chk("R7 done on release", {dn_a, dn_b, dn_c}, 3'b111);
        chk("R11 B aligned after startup", ph_b, ph_a);
        chk("R11 C aligned after startup", ph_c, ph_a);
      end
      @(negedge clk);
    end
    chk("R8 startup window length", na, 4);

    // table walk, bench drives the line; resync disabled
    for (int i = 0; i < 17; i++) begin
      pull = VEC[i][6];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 phase vec %0d", i), ph_a, VEC[i][5:2]);
      chk($sformatf("R6 cycle_start vec %0d", i), cs_a, VEC[i][1]);
      chk($sformatf("R7 sync_done vec %0d", i), dn_a, VEC[i][0]);
      chk($sformatf("R10 no drive vec %0d", i), drv_a, 0);
    end
    pull = 0;

    // isolate C and stall it so it falls one phase behind
    iso_c = 1; pull_c = 1;
    repeat (6) @(negedge clk);
    chk("R3 isolated C parked", ph_c, 4'b1000);
    chk("R4 A kept advancing", ph_a, 4'b0001);
    pull_c = 0;
    @(negedge clk);
    chk("R4 C offset from A", {ph_a, ph_c}, {4'b0010, 4'b0001});

    // reconnect and enable periodic resync
    iso_c = 0; en = 1; ival = 40;
    wait_n = 0;
    while (!dn_a && wait_n < 300) begin wait_n++; @(negedge clk); end
    chk("R9 periodic resync occurred", dn_a, 1);
    chk("R11 B realigned", ph_b, ph_a);
    chk("R11 C realigned", ph_c, ph_a);
    chk("R11 all done together", {dn_b, dn_c}, 2'b11);

    m = 0;
    while (!drv_a && m < 1000) begin m++; @(negedge clk); end
    chk("R9 interval 40 from release", m, 40);
    chk("R11 schedulers rise together", {drv_b, drv_c}, 2'b11);
    w = 0;
    while (drv_a && w < 20) begin w++; @(negedge clk); end
    chk("R9 window length", w, 4);
    chk("R3 parked at window end", {ph_a, ph_b, ph_c}, {3{4'b1000}});
    @(negedge clk);
    chk("R5 periodic release", {ph_a, ph_b, ph_c}, {3{4'b0001}});
    chk("R7 periodic done", dn_a, 1);

    // short interval measured from this release
    ival = 3;
    m = 0;
    while (!drv_a && m < 1000) begin m++; @(negedge clk); end
    chk("R9 interval 3 from release", m, 3);
    ival = 0;
    w = 0;
    while (drv_a && w < 20) begin w++; @(negedge clk); end
    chk("R9 short window length", w, 4);
    @(negedge clk);
    chk("R11 aligned after short resync", {ph_b, ph_c}, {ph_a, ph_a});

    // interval zero: no further windows
    quiet = 0;
    for (int k = 0; k < 60; k++) begin
      if (drv_a || drv_b || drv_c) quiet++;
      @(negedge clk);
    end
    chk("R10 interval zero stays quiet", quiet, 0);
    chk("R2 free running one-hot", $countones(ph_a), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule